// File: doc/BRIEF.md
# I2C Arbitration-Lost and Bus-Condition Monitor

This block sits beside an I2C controller and watches the shared open-drain bus. It synchronises the SCL and SDA pins, recognises start, repeated-start and stop conditions, and tracks whether the bus is busy. It keeps three sticky status flags: START, STOP and AL (arbitration lost).

AL has five trigger situations grouped under three enable bits. The master enable covers three of them: a transmit mismatch as master, a start condition that collides with a pending start request, and a start request raised while the bus is already busy. The NACK enable covers an ACK from another device while this one sends NACK. The slave enable covers a transmit mismatch as slave. Each trigger is gated only by its own enable bit. AL stays set until software clears it, so the transfer engine can see it and release SDA.

Software reads the flags through a plain status port. A flag clears only when 0 is written to it after a read saw it as 1. Reset and the soft reset input also clear the flags. All pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `stat_o` (bit 0 START, bit 1 STOP, bit 2 AL) and `bus_busy` are all 0.
- R2: A start or repeated start sets `stat_o[0]` and `bus_busy`. A start is synchronised SDA falling while synchronised SCL stays high.
- R3: A stop sets `stat_o[1]`, clears `stat_o[0]` and clears `bus_busy`. A stop is synchronised SDA rising while synchronised SCL stays high.
- R4: With `en_master`=1 and the mode master transmit (`is_master`=1, `is_tx`=1) outside the ACK bit (`ack_phase`=0), a rising SCL edge where `sda_drive` differs from the bus SDA sets AL.
- R5: With `en_master`=1, a detected start while `start_req`=1 and `sda_drive` differs from the bus SDA sets AL. A matching `sda_drive` leaves AL at 0.
- R6: With `en_master`=1, a `start_req_set` pulse while `bus_busy`=1 sets AL.
- R7: With `en_nack`=1, `is_tx`=0 and `ack_phase`=1, a rising SCL edge with `sda_drive`=1 and bus SDA 0 sets AL, in either master or slave mode.
- R8: With `en_slave`=1, `is_master`=0, `is_tx`=1 and `ack_phase`=0, a rising SCL edge where `sda_drive` differs from the bus SDA sets AL.
- R9: Each AL trigger depends only on its own enable bit. With that bit at 0 the trigger leaves AL at 0.
- R10: A `wr_en` write clears each flag whose `wr_data` bit is 0, but only if a read (`rd_en`) saw that flag at 1 since it last went from 0 to 1. Writing 1 has no effect, and a write of 0 without such a read has no effect.
- R11: When a set event and a write-0 clear hit the same flag in the same cycle, the flag stays 1.
- R12: `soft_rst` clears all flags and `bus_busy` on the next clock edge, and takes priority over set events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous module reset of flags and busy state |
| scl_in | input | 1 | Bus SCL level |
| sda_in | input | 1 | Bus SDA level |
| sda_drive | input | 1 | Internal SDA output value (1 = released) |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| is_tx | input | 1 | 1 = transmit, 0 = receive |
| ack_phase | input | 1 | Current bit is the ACK bit |
| start_req | input | 1 | Start-issue request pending |
| start_req_set | input | 1 | Pulse: software raises the start request |
| en_master | input | 1 | Enable for master AL triggers |
| en_nack | input | 1 | Enable for NACK AL trigger |
| en_slave | input | 1 | Enable for slave AL trigger |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 3 | Write data; 0 bits request a clear |
| stat_o | output | 3 | Flags: bit0 START, bit1 STOP, bit2 AL |
| bus_busy | output | 1 | Bus busy between start and stop |

## Verification
The assertions check on every cycle that a detected start or stop updates START, STOP and busy on the next edge. They also check that AL only rises after an enabled trigger, only falls after a soft reset or a write-0, and that a trigger always wins over a same-cycle clear. Soft-reset priority is checked the same way. Only the bench scenarios can show the correct sampling windows: mode, ACK bit and enable combinations at a real rising SCL edge, collisions at a start, and the read-before-clear sequence.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int FLAG_W  = 3;
  localparam int F_START = 0;
  localparam int F_STOP  = 1;
  localparam int F_AL    = 2;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic q
);
  logic armed, q_nxt;

  always_comb begin
    q_nxt = q;
    if (set_i) q_nxt = 1'b1;
    else if (hw_clr_i || (wr0_i && armed)) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else if (soft_rst) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else begin
      q     <= q_nxt;
      armed <= q_nxt & (armed | (rd_i & q));
    end
  end
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              sda_drive,
  input  logic              is_master,
  input  logic              is_tx,
  input  logic              ack_phase,
  input  logic              start_req,
  input  logic              start_req_set,
  input  logic              en_master,
  input  logic              en_nack,
  input  logic              en_slave,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] stat_o,
  output logic              bus_busy
);
  logic [1:0] pins_s;
  logic scl_s, sda_s, scl_rise, start_det, stop_det;
  logic mismatch, al_m_tx, al_m_start, al_m_busy, al_nack, al_slv, al_src_any;
  flag_vec_t set_v, hwclr_v, wr0_v;

  i2c_in_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_cond_detect i_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_busy <= 1'b0;
    else if (soft_rst || stop_det) bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
  end

  assign mismatch   = sda_drive ^ sda_s;
  assign al_m_tx    = en_master & scl_rise & ~ack_phase & is_master & is_tx & mismatch;
  assign al_m_start = en_master & start_det & start_req & mismatch;
  assign al_m_busy  = en_master & start_req_set & bus_busy;
  assign al_nack    = en_nack & scl_rise & ack_phase & ~is_tx & sda_drive & ~sda_s;
  assign al_slv     = en_slave & scl_rise & ~ack_phase & ~is_master & is_tx & mismatch;
  assign al_src_any = al_m_tx | al_m_start | al_m_busy | al_nack | al_slv;

  always_comb begin
    set_v          = '0;
    hwclr_v        = '0;
    set_v[F_START] = start_det;
    set_v[F_STOP]  = stop_det;
    set_v[F_AL]    = al_src_any;
    hwclr_v[F_START] = stop_det;
  end
  assign wr0_v = {FLAG_W{wr_en}} & ~wr_data;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    i2c_sticky_flag i_flag (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .set_i(set_v[i]), .hw_clr_i(hwclr_v[i]),
      .rd_i(rd_en), .wr0_i(wr0_v[i]), .q(stat_o[i])
    );
  end
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk
  import i2c_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              wr_en,
  input logic [FLAG_W-1:0] wr_data,
  input logic [FLAG_W-1:0] stat_o,
  input logic              bus_busy,
  input logic              start_det,
  input logic              stop_det,
  input logic              al_src_any
);
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !soft_rst |=> stat_o[F_START] && bus_busy); // R2
  AST_STOP_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !soft_rst |=> stat_o[F_STOP] && !stat_o[F_START] && !bus_busy); // R3
  AST_AL_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[F_AL]) |-> $past(al_src_any)); // R9
  AST_AL_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[F_AL]) |-> $past(soft_rst || (wr_en && !wr_data[F_AL]))); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    al_src_any && !soft_rst |=> stat_o[F_AL]); // R11
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> stat_o == '0 && !bus_busy); // R12
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_data(wr_data), .stat_o(stat_o), .bus_busy(bus_busy),
  .start_det(start_det), .stop_det(stop_det), .al_src_any(al_src_any)
);

// File: tb/test_i2c_arb_monitor.sv
module test_i2c_arb_monitor;
  logic clk = 1'b0;
  logic rst_n, soft_rst, scl, sda, sda_drive, is_master, is_tx, ack_phase;
  logic start_req, start_req_set, en_master, en_nack, en_slave, rd_en, wr_en;
  logic [2:0] wr_data, stat_o;
  logic bus_busy;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  i2c_arb_monitor i_i2c_arb_monitor (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .scl_in(scl), .sda_in(sda),
    .sda_drive(sda_drive), .is_master(is_master), .is_tx(is_tx),
    .ack_phase(ack_phase), .start_req(start_req), .start_req_set(start_req_set),
    .en_master(en_master), .en_nack(en_nack), .en_slave(en_slave),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .stat_o(stat_o),
    .bus_busy(bus_busy)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus(logic c, logic d);
    scl = c; sda = d; tick(4);
  endtask

  task automatic do_read();
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
  endtask

  task automatic do_write(logic [2:0] v);
    wr_en = 1'b1; wr_data = v; tick(1); wr_en = 1'b0;
  endtask

  task automatic clear_al();
    do_read(); do_write(3'b011); tick(1);
  endtask

  task automatic pulse_req();
    start_req_set = 1'b1; tick(1); start_req_set = 1'b0; tick(2);
  endtask

  function automatic logic exp_al(logic em, logic en, logic es, logic ms,
                                  logic tx, logic ak, logic drv, logic bv);
    logic mis;
    mis = drv ^ bv;
    return (em & ms & tx & ~ak & mis) | (en & ak & ~tx & drv & ~bv) |
           (es & ~ms & tx & ~ak & mis);
  endfunction

  task automatic bit_trial(logic em, logic en, logic es, logic ms,
                           logic tx, logic ak, logic drv, logic bv);
    logic e;
    string tag;
    bus(1'b0, bv);
    en_master = em; en_nack = en; en_slave = es;
    is_master = ms; is_tx = tx; ack_phase = ak; sda_drive = drv;
    tick(2);
    scl = 1'b1; tick(4);
    e = exp_al(em, en, es, ms, tx, ak, drv, bv);
    if (!e) tag = "R9 AL gated";
    else if (ak) tag = "R7 NACK AL";
    else if (ms) tag = "R4 master tx AL";
    else tag = "R8 slave tx AL";
    chk(tag, int'(stat_o[2]), int'(e));
    scl = 1'b0; tick(4);
    if (stat_o[2]) clear_al();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; soft_rst = 0; scl = 1; sda = 1; sda_drive = 1;
    is_master = 0; is_tx = 0; ack_phase = 0; start_req = 0; start_req_set = 0;
    en_master = 0; en_nack = 0; en_slave = 0; rd_en = 0; wr_en = 0; wr_data = '1;
    tick(3); rst_n = 1; tick(2);
    chk("R1 flags", int'(stat_o), 0);
    chk("R1 busy", int'(bus_busy), 0);

    bus(1, 0);
    chk("R2 start flag", int'(stat_o[0]), 1);
    chk("R2 busy", int'(bus_busy), 1);
    do_write(3'b110); tick(1);
    chk("R10 no read", int'(stat_o[0]), 1);
    do_read(); do_write(3'b111); tick(1);
    chk("R10 write one", int'(stat_o[0]), 1);
    do_write(3'b110); tick(1);
    chk("R10 clear", int'(stat_o[0]), 0);

    bus(0, 0); bus(0, 1); bus(1, 1); bus(1, 0);
    chk("R2 restart", int'(stat_o[0]), 1);

    do_read();
    bus(0, 0); bus(0, 1); bus(1, 1);
    sda = 1'b0; tick(2);
    wr_en = 1'b1; wr_data = 3'b110; tick(1); wr_en = 1'b0; tick(3);
    chk("R11 set wins", int'(stat_o[0]), 1);
    do_write(3'b110); tick(1);
    chk("R10 clear after set", int'(stat_o[0]), 0);

    bus(0, 0); bus(0, 1); bus(1, 1); bus(1, 0);
    bus(0, 0); bus(1, 0); bus(1, 1);
    chk("R3 stop flag", int'(stat_o[1]), 1);
    chk("R3 start cleared", int'(stat_o[0]), 0);
    chk("R3 busy", int'(bus_busy), 0);
    do_read(); do_write(3'b101); tick(1);
    chk("R10 stop clear", int'(stat_o[1]), 0);

    bus(1, 0);
    pulse_req();
    chk("R9 busy req disabled", int'(stat_o[2]), 0);
    en_master = 1; pulse_req();
    chk("R6 busy req", int'(stat_o[2]), 1);
    clear_al();
    chk("R10 al clear", int'(stat_o[2]), 0);
    bus(0, 0); bus(1, 0); bus(1, 1);

    start_req = 1; sda_drive = 0;
    bus(1, 0);
    chk("R5 match no AL", int'(stat_o[2]), 0);
    bus(0, 0); bus(1, 0); bus(1, 1);
    sda_drive = 1;
    bus(1, 0);
    chk("R5 start collision", int'(stat_o[2]), 1);
    clear_al(); start_req = 0;
    bus(0, 0); bus(1, 0); bus(1, 1);

    bit_trial(1, 0, 0, 1, 1, 0, 1, 0);
    bit_trial(0, 1, 1, 1, 1, 0, 1, 0);
    bit_trial(0, 1, 0, 1, 0, 1, 1, 0);
    bit_trial(0, 1, 0, 0, 0, 1, 1, 0);
    bit_trial(1, 0, 1, 1, 0, 1, 1, 0);
    bit_trial(0, 0, 1, 0, 1, 0, 0, 1);
    bit_trial(1, 1, 0, 0, 1, 0, 1, 0);
    bit_trial(1, 1, 1, 1, 1, 1, 1, 0);
    for (int k = 0; k < 80; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      bit_trial(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7]);
    end
    en_master = 0; en_nack = 0; en_slave = 0; sda_drive = 1;
    bus(0, 1); bus(1, 1);

    bus(1, 0);
    en_master = 1; pulse_req();
    soft_rst = 1; tick(1); soft_rst = 0;
    chk("R12 flags", int'(stat_o), 0);
    chk("R12 busy", int'(bus_busy), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule